// File: doc/BRIEF.md
# Write Buffer with Read-Miss Bypass

This block sits between a cache and main memory and holds stores that do not need to reach memory at once: write-through stores and dirty lines pushed out of a write-back cache. It keeps up to four word-sized entries, each with per-byte enables. It sends them to memory in arrival order whenever the shared memory port has nothing more urgent to do. A store to an address that already waits in the buffer is folded into that entry, unless the entry is the oldest one, which may already be on its way to memory.

When the cache misses on a read, the buffer compares the miss address with every buffered entry. If nothing matches, the read takes the memory port before any waiting write, so the requester is not held behind the write traffic. If the newest matching entry carries all bytes, the buffer answers the read itself. If that entry is only partly written, the read waits until the buffer has written the matching entries out, and then reads memory. A write-back cache evicting a dirty line first pushes the victim into the buffer and then presents the read. The requester gets its data as soon as the read returns, while the victim write is still pending.

Top module: `wbuf_rdprio`

## Requirements
- R1: After reset, wr_full, mem_req_valid and rd_resp_valid are low and rd_ready is high.
- R2: A store is accepted in any cycle where wr_valid is high and wr_full is low. wr_full goes high when four distinct addresses are buffered, and a store presented while wr_full is high is dropped and never reaches memory.
- R3: Buffered entries leave as memory write requests (mem_req_write = 1) in arrival order, and each carries its address, data and byte enables. Byte-enable bit b covers data bits 8b+7 down to 8b.
- R4: A store whose address matches a buffered entry other than the oldest one is merged into the newest such entry. Enabled bytes are replaced, the byte enables are ORed, and no entry is used.
- R5: A read miss with no matching entry is issued as a memory read (mem_req_write = 0) before any write still waiting in the buffer.
- R6: A memory request that has been raised keeps its valid, kind, address and data until mem_req_ready accepts it. A write already offered therefore completes before a read overtakes the queue.
- R7: When the newest entry matching a read has all four byte enables set, rd_resp_valid is high for one cycle with that entry's data. This happens at the second clock edge after the read is accepted, and no memory read is made.
- R8: When the newest matching entry is partly valid, the read issues no response and rd_ready stays low until the matching entries have been written to memory. The read is then sent to memory.
- R9: A memory read answer (mem_rsp_valid) is passed to rd_resp_data with rd_resp_valid at the next edge, and rd_ready returns high.
- R10: A store accepted in the same cycle as a read request is visible to that read's address check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store present |
| wr_addr | input | ADDR_W | Store word address |
| wr_data | input | DATA_W | Store data |
| wr_be | input | DATA_W/8 | Store byte enables |
| wr_full | output | 1 | No entry free; stores are not taken |
| rd_valid | input | 1 | Read miss present |
| rd_addr | input | ADDR_W | Read miss word address |
| rd_ready | output | 1 | Read miss accepted when high |
| rd_resp_valid | output | 1 | Read data returned |
| rd_resp_data | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_data | output | DATA_W | Write data |
| mem_req_be | output | DATA_W/8 | Write byte enables |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DATA_W | Memory read data |

## Verification
The assertions assume a well-behaved memory side. mem_rsp_valid arrives as a single pulse, only after a read request has been accepted, and memory serves requests in the order it accepts them. They also assume that rd_valid is only raised while rd_ready is high. The bench memory model answers each accepted read once, one cycle after acceptance, and never answers writes. Stores are presented as single-cycle pulses, and a store is sent while wr_full is high only where the drop is the thing under test. Back-pressure comes from holding mem_req_ready low, which keeps the oldest entry parked on the port and gives the read-bypass cases a write in flight.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_CHECK = 2'd1,
    RD_MEM   = 2'd2
  } rd_state_t;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               push,
  input  logic                               merge,
  input  logic [$clog2(DEPTH)-1:0]           merge_idx,
  input  logic                               pop,
  input  logic [ADDR_W-1:0]                  in_addr,
  input  logic [DATA_W-1:0]                  in_data,
  input  logic [DATA_W/8-1:0]                in_be,
  output logic [DEPTH-1:0][ADDR_W-1:0]       e_addr,
  output logic [DEPTH-1:0][DATA_W-1:0]       e_data,
  output logic [DEPTH-1:0][DATA_W/8-1:0]     e_be,
  output logic [$clog2(DEPTH+1)-1:0]         count
);
  localparam int BE_W  = DATA_W / 8;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][ADDR_W-1:0] n_addr;
  logic [DEPTH-1:0][DATA_W-1:0] n_data;
  logic [DEPTH-1:0][BE_W-1:0]   n_be;
  logic [CNT_W-1:0]             wpos;
  logic [IDX_W-1:0]             mpos;

  // Oldest entry sits at index 0; a pop shifts the queue down by one.
  always_comb begin
    n_addr = e_addr;
    n_data = e_data;
    n_be   = e_be;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        n_addr[i] = e_addr[i+1];
        n_data[i] = e_data[i+1];
        n_be[i]   = e_be[i+1];
      end
    end
    wpos = count - CNT_W'(pop);
    mpos = merge_idx - IDX_W'(pop);
    if (push) begin
      n_addr[wpos[IDX_W-1:0]] = in_addr;
      n_data[wpos[IDX_W-1:0]] = in_data;
      n_be[wpos[IDX_W-1:0]]   = in_be;
    end
    if (merge) begin
      for (int b = 0; b < BE_W; b++) begin
        if (in_be[b]) n_data[mpos][b*8 +: 8] = in_data[b*8 +: 8];
      end
      n_be[mpos] = n_be[mpos] | in_be;
    end
  end

  always_ff @(posedge clk) begin
    e_addr <= n_addr;
    e_data <= n_data;
    e_be   <= n_be;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + CNT_W'(push) - CNT_W'(pop);
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    !(push && !pop && count == CNT_W'(DEPTH)));

  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);

  p_merge_target_r4: assert property (@(posedge clk) disable iff (rst)
    merge |-> (merge_idx != '0 && CNT_W'(merge_idx) < count && !push));
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] e_addr,
  input  logic [$clog2(DEPTH+1)-1:0]   count,
  input  logic [ADDR_W-1:0]            look,
  output logic                         hit,
  output logic [$clog2(DEPTH)-1:0]     hit_idx
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] cmp;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign cmp[g] = (CNT_W'(g) < count) && (e_addr[g] == look);
  end

  // Highest matching index is the newest copy of the address.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cmp[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |cmp;
endmodule

// File: rtl/wbuf_port.sv
module wbuf_port
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_valid,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic                        rd_ready,
  output logic [ADDR_W-1:0]           rd_addr_q,
  output logic                        rd_resp_valid,
  output logic [DATA_W-1:0]           rd_resp_data,
  input  logic                        rchk_hit,
  input  logic                        rchk_full,
  input  logic [DATA_W-1:0]           rchk_data,
  input  logic [$clog2(DEPTH+1)-1:0]  count,
  input  logic [ADDR_W-1:0]           head_addr,
  input  logic [DATA_W-1:0]           head_data,
  input  logic [DATA_W/8-1:0]         head_be,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic                        mem_req_write,
  output logic [ADDR_W-1:0]           mem_req_addr,
  output logic [DATA_W-1:0]           mem_req_data,
  output logic [DATA_W/8-1:0]         mem_req_be,
  input  logic                        mem_rsp_valid,
  input  logic [DATA_W-1:0]           mem_rsp_data,
  output logic                        pop
);
  rd_state_t rstate;
  logic      read_go;
  logic      write_go;

  assign rd_ready = (rstate == RD_IDLE);
  assign pop      = mem_req_valid && mem_req_ready && mem_req_write;
  assign read_go  = (rstate == RD_CHECK) && !rchk_hit && !mem_req_valid;
  assign write_go = !mem_req_valid && !read_go && (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rstate        <= RD_IDLE;
      rd_resp_valid <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
    end else begin
      rd_resp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) mem_req_valid <= 1'b0;
      if (read_go) begin
        mem_req_valid <= 1'b1;
        mem_req_write <= 1'b0;
        mem_req_addr  <= rd_addr_q;
        mem_req_data  <= '0;
        mem_req_be    <= '0;
      end else if (write_go) begin
        mem_req_valid <= 1'b1;
        mem_req_write <= 1'b1;
        mem_req_addr  <= head_addr;
        mem_req_data  <= head_data;
        mem_req_be    <= head_be;
      end
      case (rstate)
        RD_IDLE: if (rd_valid) begin
          rd_addr_q <= rd_addr;
          rstate    <= RD_CHECK;
        end
        RD_CHECK: begin
          if (rchk_hit && rchk_full) begin
            rd_resp_valid <= 1'b1;
            rd_resp_data  <= rchk_data;
            rstate        <= RD_IDLE;
          end else if (read_go) begin
            rstate <= RD_MEM;
          end
        end
        RD_MEM: if (mem_rsp_valid) begin
          rd_resp_valid <= 1'b1;
          rd_resp_data  <= mem_rsp_data;
          rstate        <= RD_IDLE;
        end
        default: rstate <= RD_IDLE;
      endcase
    end
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_data)));

  p_rdreq_owner_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_write) |-> rstate == RD_MEM);

  p_resp_single_r9: assert property (@(posedge clk) disable iff (rst)
    rd_resp_valid |=> !rd_resp_valid);

  p_resp_frees_r7: assert property (@(posedge clk) disable iff (rst)
    rd_resp_valid |-> rd_ready);

  p_rsp_expected_r9: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> rstate == RD_MEM);
endmodule

// File: rtl/wbuf_rdprio.sv
module wbuf_rdprio #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_be,
  output logic                wr_full,
  input  logic                rd_valid,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_ready,
  output logic                rd_resp_valid,
  output logic [DATA_W-1:0]   rd_resp_data,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_data,
  output logic [DATA_W/8-1:0] mem_req_be,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_data
);
  localparam int BE_W  = DATA_W / 8;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][ADDR_W-1:0] e_addr;
  logic [DEPTH-1:0][DATA_W-1:0] e_data;
  logic [DEPTH-1:0][BE_W-1:0]   e_be;
  logic [CNT_W-1:0]             count;
  logic [ADDR_W-1:0]            rd_addr_q;
  logic                         wm_hit, rchk_hit;
  logic [IDX_W-1:0]             wm_idx, rchk_idx;
  logic                         wr_acc, push, merge, pop;

  assign wr_full = (count == CNT_W'(DEPTH));
  assign wr_acc  = wr_valid && !wr_full;
  assign merge   = wr_acc && wm_hit && (wm_idx != '0);
  assign push    = wr_acc && !merge;

  wbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(push), .merge(merge), .merge_idx(wm_idx), .pop(pop),
    .in_addr(wr_addr), .in_data(wr_data), .in_be(wr_be),
    .e_addr(e_addr), .e_data(e_data), .e_be(e_be), .count(count)
  );

  wbuf_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_wmatch (
    .e_addr(e_addr), .count(count), .look(wr_addr), .hit(wm_hit), .hit_idx(wm_idx)
  );

  wbuf_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rmatch (
    .e_addr(e_addr), .count(count), .look(rd_addr_q), .hit(rchk_hit), .hit_idx(rchk_idx)
  );

  wbuf_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_port (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_addr_q(rd_addr_q), .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .rchk_hit(rchk_hit), .rchk_full(&e_be[rchk_idx]), .rchk_data(e_data[rchk_idx]),
    .count(count), .head_addr(e_addr[0]), .head_data(e_data[0]), .head_be(e_be[0]),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_data(mem_req_data), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .pop(pop)
  );

  p_full_no_store_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_full && !pop) |=> wr_full);
endmodule

// File: tb/wbuf_rdprio_test.sv
module wbuf_rdprio_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        wr_full;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        rd_ready, rd_resp_valid;
  logic [31:0] rd_resp_data;
  logic        mem_req_valid, mem_req_write;
  logic        mem_rdy = 1'b0;
  logic [15:0] mem_req_addr;
  logic [31:0] mem_req_data;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int checks = 0;
  int fails  = 0;

  logic        log_wr   [64];
  logic [15:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [3:0]  log_be   [64];
  int          log_n;
  logic        rsp_pend;
  logic [15:0] rsp_addr;

  localparam logic [51:0] TBL [4] = '{
    {16'h0100, 32'h0101_0101, 4'hF},
    {16'h0104, 32'h0202_0202, 4'h3},
    {16'h0108, 32'h0303_0303, 4'hC},
    {16'h010C, 32'h0404_0404, 4'hF}
  };

  always #2.5 clk = ~clk;

  wbuf_rdprio uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .wr_full(wr_full), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_rdy), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] mdl(logic [15:0] a);
    return {16'hD00D, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: logs accepted requests, answers reads one cycle later.
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    rsp_pend      = 1'b0;
    rsp_addr      = '0;
    log_n         = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rsp_pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mdl(rsp_addr);
        rsp_pend      = 1'b0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      if (!rst && mem_req_valid && mem_rdy && log_n < 64) begin
        log_wr[log_n]   = mem_req_write;
        log_addr[log_n] = mem_req_addr;
        log_data[log_n] = mem_req_data;
        log_be[log_n]   = mem_req_be;
        log_n++;
        if (!mem_req_write) begin
          rsp_pend = 1'b1;
          rsp_addr = mem_req_addr;
        end
      end
    end
  end

  task automatic push_wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic wait_resp(output logic got, output logic [31:0] d);
    got = 1'b0;
    d   = '0;
    for (int k = 0; k < 30 && !got; k++) begin
      @(negedge clk);
      if (rd_resp_valid) begin
        got = 1'b1;
        d   = rd_resp_data;
      end
    end
  endtask

  task automatic drain();
    @(negedge clk);
    mem_rdy = 1'b1;
    repeat (14) @(negedge clk);
    mem_rdy = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base;
    logic got;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 wr_full after reset", wr_full, 0);
    chk("R1 rd_ready after reset", rd_ready, 1);
    chk("R1 mem_req_valid after reset", mem_req_valid, 0);
    chk("R1 rd_resp_valid after reset", rd_resp_valid, 0);

    // Table-driven fill and FIFO drain
    base = log_n;
    for (int k = 0; k < 4; k++) push_wr(TBL[k][51:36], TBL[k][35:4], TBL[k][3:0]);
    chk("R2 full after four stores", wr_full, 1);
    push_wr(16'h0099, 32'hDEAD_BEEF, 4'hF);
    chk("R6 head write held valid", mem_req_valid, 1);
    chk("R6 head write held kind", mem_req_write, 1);
    chk("R6 head write held addr", mem_req_addr, TBL[0][51:36]);
    drain();
    chk("R2 store while full dropped", log_n - base, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R3 drain kind", log_wr[base+k], 1);
      chk("R3 drain addr", log_addr[base+k], TBL[k][51:36]);
      chk("R3 drain data", log_data[base+k], TBL[k][35:4]);
      chk("R3 drain be", log_be[base+k], TBL[k][3:0]);
    end
    chk("R2 not full after drain", wr_full, 0);

    // Merge
    base = log_n;
    push_wr(16'h0010, 32'h1111_1111, 4'hF);
    push_wr(16'h0020, 32'h2222_2222, 4'h3);
    push_wr(16'h0020, 32'hAAAA_0000, 4'hC);
    push_wr(16'h0030, 32'h3333_3333, 4'hF);
    chk("R4 merge used no slot", wr_full, 0);
    push_wr(16'h0040, 32'h4444_4444, 4'hF);
    chk("R4 full after fourth entry", wr_full, 1);
    drain();
    chk("R4 entry count", log_n - base, 4);
    chk("R4 merged addr", log_addr[base+1], 32'h0020);
    chk("R4 merged data", log_data[base+1], 32'hAAAA_2222);
    chk("R4 merged be", log_be[base+1], 4'hF);
    chk("R4 last entry addr", log_addr[base+3], 32'h0040);

    // Read bypass with a write in flight
    base = log_n;
    push_wr(16'h0050, 32'h5050_5050, 4'hF);
    push_wr(16'h0060, 32'h6060_6060, 4'hF);
    do_read(16'h0070);
    repeat (3) @(negedge clk);
    chk("R6 read waits behind offered write", log_n - base, 0);
    chk("R9 requester busy", rd_ready, 0);
    mem_rdy = 1'b1;
    wait_resp(got, d);
    chk("R9 memory read returned", got, 1);
    chk("R9 memory read data", d, mdl(16'h0070));
    chk("R9 rd_ready back", rd_ready, 1);
    repeat (6) @(negedge clk);
    mem_rdy = 1'b0;
    chk("R6 in-flight write first", log_addr[base], 32'h0050);
    chk("R5 read second kind", log_wr[base+1], 0);
    chk("R5 read second addr", log_addr[base+1], 32'h0070);
    chk("R5 queued write after read", log_addr[base+2], 32'h0060);
    chk("R5 queued write kind", log_wr[base+2], 1);

    // Forward from newest full entry
    base = log_n;
    push_wr(16'h0080, 32'h8080_8080, 4'hF);
    push_wr(16'h0090, 32'h9090_9090, 4'hF);
    push_wr(16'h0080, 32'h8A8A_8A8A, 4'hF);
    do_read(16'h0080);
    @(negedge clk);
    chk("R7 forward valid", rd_resp_valid, 1);
    chk("R7 forward newest data", rd_resp_data, 32'h8A8A_8A8A);
    chk("R7 no memory read", log_n - base, 0);
    drain();
    chk("R7 head not merged: three writes", log_n - base, 3);

    // Partial match stalls
    base = log_n;
    push_wr(16'h00A0, 32'hA0A0_A0A0, 4'hF);
    push_wr(16'h00B0, 32'h0000_BEEF, 4'h3);
    do_read(16'h00B0);
    repeat (4) @(negedge clk);
    chk("R8 no response while partial", rd_resp_valid, 0);
    chk("R8 rd_ready low while partial", rd_ready, 0);
    mem_rdy = 1'b1;
    wait_resp(got, d);
    chk("R8 response after drain", got, 1);
    chk("R8 data from memory", d, mdl(16'h00B0));
    repeat (4) @(negedge clk);
    mem_rdy = 1'b0;
    chk("R8 first write", log_addr[base], 32'h00A0);
    chk("R8 partial entry written before read", log_addr[base+1], 32'h00B0);
    chk("R8 partial entry kind", log_wr[base+1], 1);
    chk("R8 read after drain", log_wr[base+2], 0);

    // Store and read in the same cycle
    base = log_n;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 16'h00C0; wr_data = 32'hCAFE_F00D; wr_be = 4'hF;
    rd_valid = 1'b1; rd_addr = 16'h00C0;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    @(negedge clk);
    chk("R10 same-cycle store forwarded", rd_resp_valid, 1);
    chk("R10 same-cycle data", rd_resp_data, 32'hCAFE_F00D);
    chk("R10 no memory read", log_n - base, 0);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule